// File: doc/BRIEF.md
# GPIO Pin Interrupt Detection Unit

This block watches a group of general-purpose input pins and turns activity on them into interrupt conditions. Each pin has its own settings. It can look for a level (high or low), for a single edge (rising or falling), or for both edges. The pins are asynchronous, so the block first brings them into the clock domain with a two-stage synchronizer. It then finds edges by comparing each synchronized sample with the sample taken one cycle earlier.

Detected conditions are latched into a raw status vector, whatever the mask settings are. The raw status ANDed with an enable mask gives the masked status. The OR of the masked bits drives a single combined interrupt line toward an interrupt controller. Software reaches the bank through a simple read/write port: a one-cycle write strobe with an address and data, and a combinational read at any address. A status bit is cleared by writing a 1 to the matching bit of the clear register.

The block has no streaming data path. Every port is a plain control or status signal, so no valid/ready back-pressure applies.

Top module: `gpio_irq_detect`

## Requirements
- R1: A pin change driven between clock edges first appears in raw status after the third rising clock edge that follows it, and not after the second.
- R2: With mode bit 0 and dual bit 0, a pin triggers on a rising edge only when its polarity bit is 1, and on a falling edge only when its polarity bit is 0.
- R3: With mode bit 0 and dual bit 1, a pin triggers on both rising and falling edges, whatever its polarity bit is.
- R4: With mode bit 1, a pin triggers while its synchronized level equals its polarity bit (1 = high, 0 = low). The raw bit is set again on every cycle that the level persists, so a clear has no lasting effect until the level goes away.
- R5: A raw status bit is set by its pin's condition whether or not the pin is enabled in the mask, and it stays set until it is cleared.
- R6: Masked status equals raw status AND the mask register. The output irq_o is 1 exactly when any masked status bit is 1.
- R7: A write of 1 to a bit of the clear register clears that raw bit. A write of 0 leaves the bit unchanged.
- R8: Register offsets are: 0 mode (1 = level), 1 dual-edge, 2 polarity, 3 mask, 4 raw status (read-only), 5 masked status (read-only), 6 clear (write-only, reads 0), 7 reads 0. Mode, dual-edge, polarity, mask and raw status are all zero after reset. Writes to offsets 4 and 5 are ignored.
- R9: When a detection and a clear hit the same bit in the same cycle, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | NPINS | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | NPINS | Combinational read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the register port is driven synchronously and that each clear is a single write strobe. They also assume that the pins are all low at reset, so the reset value of the synchronizer does not produce a false edge. The stimulus changes pins and write controls one time unit after a rising edge and keeps the pins low through reset. It holds each pin steady for at least three cycles, so every change fully crosses the synchronizer before the next one. The same-cycle collision case times the clear strobe to land on the edge where the detection is registered.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE  = 3'd0,
    REG_DUAL  = 3'd1,
    REG_POL   = 3'd2,
    REG_MASK  = 3'd3,
    REG_RAW   = 3'd4,
    REG_MSKD  = 3'd5,
    REG_CLR   = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPINS = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  output logic [NPINS-1:0] cur_o,
  output logic [NPINS-1:0] prv_o
);
  logic [NPINS-1:0] stage_q [STAGES];

  // synchronizer chain; the last stage is the "current" sample
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= pins_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_o <= '0;
    else        prv_o <= stage_q[STAGES-1];
  end

  assign cur_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cond_detect.sv
module gpio_cond_detect #(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] cur_i,
  input  logic [NPINS-1:0] prv_i,
  input  logic [NPINS-1:0] mode_i,
  input  logic [NPINS-1:0] dual_i,
  input  logic [NPINS-1:0] pol_i,
  output logic [NPINS-1:0] det_o
);
  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic rise, fall, lvl_hit, edge_hit;
      always_comb begin
        rise     = cur_i[p] & ~prv_i[p];
        fall     = ~cur_i[p] & prv_i[p];
        lvl_hit  = (cur_i[p] == pol_i[p]);
        if (dual_i[p]) edge_hit = rise | fall;
        else           edge_hit = pol_i[p] ? rise : fall;
        det_o[p] = mode_i[p] ? lvl_hit : edge_hit;
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  output logic [NPINS-1:0]  mode_o,
  output logic [NPINS-1:0]  dual_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  clr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= '0;
      dual_o <= '0;
      pol_o  <= '0;
      mask_o <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_MODE: mode_o <= wr_data;
        REG_DUAL: dual_o <= wr_data;
        REG_POL:  pol_o  <= wr_data;
        REG_MASK: mask_o <= wr_data;
        default: ;
      endcase
    end
  end

  // clear strobes act in the write cycle itself
  assign clr_o = (wr_en && wr_addr == REG_CLR) ? wr_data : '0;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NPINS-1:0]  rd_data,
  output logic              irq_o
);
  logic [NPINS-1:0] cur, prv, det;
  logic [NPINS-1:0] mode, dual, pol, mask, clr;
  logic [NPINS-1:0] raw_q, masked;

  gpio_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .cur_o(cur), .prv_o(prv)
  );

  gpio_cond_detect #(.NPINS(NPINS)) u_det (
    .cur_i(cur), .prv_i(prv), .mode_i(mode), .dual_i(dual), .pol_i(pol),
    .det_o(det)
  );

  gpio_irq_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_o(mode), .dual_o(dual), .pol_o(pol),
    .mask_o(mask), .clr_o(clr)
  );

  // detection takes priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr) | det;
  end

  assign masked = raw_q & mask;
  assign irq_o  = |masked;

  always_comb begin
    case (rd_addr)
      REG_MODE: rd_data = mode;
      REG_DUAL: rd_data = dual;
      REG_POL:  rd_data = pol;
      REG_MASK: rd_data = mask;
      REG_RAW:  rd_data = raw_q;
      REG_MSKD: rd_data = masked;
      default:  rd_data = '0;
    endcase
  end

  // every detected pin shows up in raw status one cycle later
  assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (det != '0) |=> ((raw_q & $past(det)) == $past(det)));

  // a clear with no competing detection empties the bit
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~det) != '0) |=> ((raw_q & $past(clr & ~det)) == '0));

  // a raw bit rises only after a detection on its pin
  assert_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~$past(raw_q) & ~$past(det)) == '0));

  // no detection and no clear: status holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (det == '0 && clr == '0) |=> $stable(raw_q));

  // colliding clear never drops a detected bit
  assert_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & det) != '0) |=> ((raw_q & $past(clr & det)) == $past(clr & det)));

  // single-edge rising pins fire only on a 0->1 sample pair
  assert_rise_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((det & ~mode & ~dual & pol & ~(cur & ~prv)) == '0));
endmodule

// File: tb/gpio_irq_detect_test.sv
`timescale 1ns/1ps
module gpio_irq_detect_test;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] pins = '0;
  logic wr_en = 0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [N-1:0] wr_data = '0, rd_data;
  logic irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  gpio_irq_detect #(.NPINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [N-1:0] exp);
    logic [N-1:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) chk_reg("R8 reset", a[2:0], '0);
    chk("R8 irq reset", irq, 1'b0);
  endtask

  task automatic t_rise();
    wr(3'd3, 8'h01); wr(3'd2, 8'h01);
    pins = 8'h01;
    cyc(2); chk_reg("R1 not yet", 3'd4, 8'h00);
    cyc(1); chk_reg("R1/R2 rise", 3'd4, 8'h01);
    chk("R6 irq on", irq, 1'b1);
    wr(3'd6, 8'h01); chk_reg("R7 clear", 3'd4, 8'h00);
    chk("R6 irq off", irq, 1'b0);
    pins = 8'h00; cyc(4); chk_reg("R2 fall ignored", 3'd4, 8'h00);
  endtask

  task automatic t_fall();
    pins = 8'h02; cyc(4); chk_reg("R2 rise ignored", 3'd4, 8'h00);
    pins = 8'h00; cyc(3); chk_reg("R2 fall", 3'd4, 8'h02);
    wr(3'd6, 8'h02); chk_reg("R7 clear", 3'd4, 8'h00);
  endtask

  task automatic t_both();
    wr(3'd1, 8'h04);
    pins = 8'h04; cyc(3); chk_reg("R3 rise", 3'd4, 8'h04);
    wr(3'd6, 8'h04);
    pins = 8'h00; cyc(3); chk_reg("R3 fall", 3'd4, 8'h04);
    wr(3'd6, 8'h04); chk_reg("R7 clear", 3'd4, 8'h00);
  endtask

  task automatic t_level();
    wr(3'd0, 8'h08); wr(3'd2, 8'h09);
    pins = 8'h08; cyc(3); chk_reg("R4 high", 3'd4, 8'h08);
    wr(3'd6, 8'h08); chk_reg("R4 persists", 3'd4, 8'h08);
    pins = 8'h00; cyc(3); chk_reg("R5 held", 3'd4, 8'h08);
    wr(3'd6, 8'h08); chk_reg("R4 cleared", 3'd4, 8'h00);
    wr(3'd0, 8'h18); cyc(1); chk_reg("R4 low", 3'd4, 8'h10);
    wr(3'd0, 8'h00); wr(3'd6, 8'hFF); chk_reg("R7 clear", 3'd4, 8'h00);
  endtask

  task automatic t_mask();
    wr(3'd2, 8'h29);
    pins = 8'h20; cyc(3); chk_reg("R5 unmasked raw", 3'd4, 8'h20);
    chk_reg("R6 masked 0", 3'd5, 8'h00);
    chk("R6 irq masked", irq, 1'b0);
    wr(3'd3, 8'h21); chk_reg("R6 masked", 3'd5, 8'h20);
    chk("R6 irq", irq, 1'b1);
    wr(3'd6, 8'h00); chk_reg("R7 zero write", 3'd4, 8'h20);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00); chk_reg("R8 ro", 3'd4, 8'h20);
    wr(3'd6, 8'h20); chk_reg("R7 clear", 3'd4, 8'h00);
    chk("R6 irq off", irq, 1'b0);
    chk_reg("R8 clr reads 0", 3'd6, 8'h00);
  endtask

  task automatic t_collide();
    wr(3'd1, 8'h44);
    pins = 8'h60; cyc(3); chk_reg("R3 rise", 3'd4, 8'h40);
    pins = 8'h20; cyc(2);
    wr(3'd6, 8'h40);
    chk_reg("R9 detect wins", 3'd4, 8'h40);
    wr(3'd6, 8'h40); chk_reg("R7 clear", 3'd4, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_mask();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule